// File: doc/BRIEF.md
# Stereo ADC Serial Transmit Port with Short-Frame Dither

This block sends pairs of 24-bit stereo converter samples out over a three-wire serial audio link where both the bit clock and the frame clock come from the far end. A static select input picks one of two framings: I2S, or left-justified. The same select is passed back out so that the receive side of the link can use the same framing. The block runs in the system clock domain. It oversamples the incoming bit clock and frame clock, and it updates its data output after each bit-clock falling edge it detects. The far end samples on the rising edge.

The block counts the bit-clock periods in every frame-clock period. When it sees a 32-to-1 ratio, it narrows the words it sends to 16 bits. Before it drops the lower bits, it adds a one-bit pseudo-random dither at the bit position just below the kept LSB. If this addition would overflow, the result is clamped at the largest positive 16-bit code. At any other ratio, the full 24-bit samples are sent unchanged. A single odd frame cannot toggle the width, because a change needs two consecutive periods that agree.

Top module: `adc_serial_tx`

## Requirements
- R1: With fmtI2s = 0 (left-justified), frame-clock high carries the left word and low carries the right word. The MSB of each word is driven on the first bit-clock falling edge at which the new frame-clock level is seen.
- R2: With fmtI2s = 1 (I2S), frame-clock low carries the left word and high carries the right word. The MSB is driven one bit-clock period after the frame-clock transition.
- R3: sdout changes only after a detected bit-clock falling edge. Slots after the last bit of a word are zero. In I2S framing, the final bit of a word lands in the first slot of the following half-frame. If the half-frame is longer than 24 slots, that first slot is zero instead.
- R4: The ratio is measured as the number of bit-clock falling edges between consecutive left-word starts. The partial period before the first left-word start after reset is ignored. The 16-bit mode turns on or off only when two consecutive measured periods agree. Words loaded at a left-word start use the mode that held before that start.
- R5: A single period with a different ratio, placed between periods of ratio 32, leaves the mode unchanged.
- R6: In 16-bit mode, each word is the upper 16 bits of (sample + dither × 2^7), computed in two's complement. The 16 bits are sent MSB first and followed by zeros.
- R7: In 16-bit mode, when the addition in R6 would carry a non-negative sample past the top of the range, the word is 0x7FFF.
- R8: The dither comes from a 16-bit LFSR with seed 0xACE1 and feedback bit15^bit13^bit12^bit10, shifted in at bit 0. The dither bit is bit 15 before the step. The LFSR steps once at each left-word start, and both words of that frame use the same dither bit.
- R9: When the ratio is not 32, words are the 24-bit samples without dither.
- R10: fmtExport always equals fmtI2s.
- R11: While reset is low, and right after it is released, sdout is 0 and the mode is 24-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial clocks |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Bit clock supplied by the far end |
| lrckIn | input | 1 | Frame clock supplied by the far end |
| fmtI2s | input | 1 | Framing select: 1 for I2S, 0 for left-justified |
| leftSample | input | 24 | Left sample, two's complement, captured at the left-word start |
| rightSample | input | 24 | Right sample, two's complement, captured at the left-word start |
| sdout | output | 1 | Serial data out |
| fmtExport | output | 1 | Framing select passed on to the receive path |

## Verification
The bench uses the default parameters: 24-bit samples, 16-bit short words, a short ratio of 32, an 8-bit edge counter and two synchronizer stages. The bit clock runs at a half-period of six system clocks. With these values, frames of 32, 48 and 64 bit clocks are all reachable, so the I2S last-bit spill can be checked with both 16-bit and 24-bit words. The 16-bit mode can also be entered, disturbed by one odd frame, and left again. The seed puts a set dither bit into the first frames of 16-bit mode, so the saturation clamp on a full-scale positive input is exercised within a dozen frames.

// File: rtl/adc_serial_tx_pkg.sv
package adc_serial_tx_pkg;

  // Strobes from the control to the datapath, all single-cycle except levels
  typedef struct packed {
    logic bitTick;    // bit-clock falling edge seen this cycle
    logic loadLeft;   // left word starts on this tick
    logic loadRight;  // right word starts on this tick
    logic useShort;   // level: 16-bit dithered words
    logic i2sMode;    // level: one-slot delayed framing
  } txStrobes_t;

endpackage

// File: rtl/adc_serial_tx_ctrl.sv
module adc_serial_tx_ctrl
  import adc_serial_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int SHORT_RATIO = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       lrckIn,
  input  logic       fmtI2s,
  output txStrobes_t strobes
);

  localparam logic [CNT_W-1:0] CNT_TOP   = '1;
  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_RATIO);

  logic [SYNC_STAGES-1:0] sclkPipe;
  logic [SYNC_STAGES-1:0] lrckPipe;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclkPipe[0] <= 1'b0;
          lrckPipe[0] <= 1'b0;
        end else begin
          sclkPipe[0] <= sclkIn;
          lrckPipe[0] <= lrckIn;
        end
      end
    end else begin : gRest
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclkPipe[g] <= 1'b0;
          lrckPipe[g] <= 1'b0;
        end else begin
          sclkPipe[g] <= sclkPipe[g-1];
          lrckPipe[g] <= lrckPipe[g-1];
        end
      end
    end
  end

  logic sclkNow, lrckNow;
  logic sclkLast, lrckSeen;
  logic fallTick, lrckMoved, leftLevel;
  logic loadLeft, loadRight;
  logic [CNT_W-1:0] edgeCount;
  logic periodValid, haveMeas, lastMeas, shortMode, measShort;

  assign sclkNow   = sclkPipe[SYNC_STAGES-1];
  assign lrckNow   = lrckPipe[SYNC_STAGES-1];
  assign fallTick  = sclkLast & ~sclkNow;
  assign leftLevel = ~fmtI2s;
  assign lrckMoved = lrckNow ^ lrckSeen;
  assign loadLeft  = fallTick & lrckMoved & (lrckNow == leftLevel);
  assign loadRight = fallTick & lrckMoved & (lrckNow != leftLevel);
  assign measShort = (edgeCount == SHORT_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkLast    <= 1'b0;
      lrckSeen    <= 1'b0;
      edgeCount   <= '0;
      periodValid <= 1'b0;
      haveMeas    <= 1'b0;
      lastMeas    <= 1'b0;
      shortMode   <= 1'b0;
    end else begin
      sclkLast <= sclkNow;
      if (fallTick) begin
        lrckSeen <= lrckNow;
        if (loadLeft) begin
          edgeCount <= CNT_W'(1);
        end else if (edgeCount != CNT_TOP) begin
          edgeCount <= edgeCount + CNT_W'(1);
        end
      end
      if (loadLeft) begin
        periodValid <= 1'b1;
        if (periodValid) begin
          if (haveMeas && (measShort == lastMeas)) begin
            shortMode <= measShort;
          end
          lastMeas <= measShort;
          haveMeas <= 1'b1;
        end
      end
    end
  end

  assign strobes.bitTick   = fallTick;
  assign strobes.loadLeft  = loadLeft;
  assign strobes.loadRight = loadRight;
  assign strobes.useShort  = shortMode;
  assign strobes.i2sMode   = fmtI2s;

  AST_MODE_AT_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !loadLeft |=> $stable(shortMode)); // R5

  AST_MODE_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rstN)
    !haveMeas |-> !shortMode); // R4

endmodule

// File: rtl/adc_serial_tx_dither.sv
module adc_serial_tx_dither #(
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rstN,
  input  logic step,
  output logic ditherBit
);

  logic [LFSR_W-1:0] lfsrState;
  logic              feedBack;

  assign feedBack  = ^(lfsrState & LFSR_TAPS);
  assign ditherBit = lfsrState[LFSR_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrState <= LFSR_SEED;
    end else if (step) begin
      lfsrState <= {lfsrState[LFSR_W-2:0], feedBack};
    end
  end

  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != '0); // R8

  AST_LFSR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(lfsrState)); // R8

endmodule

// File: rtl/adc_serial_tx_dp.sv
module adc_serial_tx_dp
  import adc_serial_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobes_t          strobes,
  input  logic                ditherBit,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  output logic                sdout
);

  localparam int DROP_W     = SAMPLE_W - SHORT_W;
  localparam int DITHER_POS = DROP_W - 1;
  localparam int TOP        = SAMPLE_W - 1;

  function automatic logic [SAMPLE_W-1:0] shapeWord(
    input logic [SAMPLE_W-1:0] raw,
    input logic                shortMode,
    input logic                dith
  );
    logic [SAMPLE_W-1:0] sum;
    logic [SAMPLE_W-1:0] res;
    sum = raw + (SAMPLE_W'(dith) << DITHER_POS);
    if (!shortMode) begin
      res = raw;
    end else if (!raw[TOP] && sum[TOP]) begin
      res = {1'b0, {(SHORT_W-1){1'b1}}, {DROP_W{1'b0}}};
    end else begin
      res = {sum[TOP -: SHORT_W], {DROP_W{1'b0}}};
    end
    return res;
  endfunction

  logic [SAMPLE_W-1:0] wordLeft, wordRight, loadWord;
  logic [SAMPLE_W-1:0] holdRight, shiftReg;
  logic                sdoutReg;

  assign wordLeft  = shapeWord(leftSample, strobes.useShort, ditherBit);
  assign wordRight = shapeWord(rightSample, strobes.useShort, ditherBit);
  assign loadWord  = strobes.loadLeft ? wordLeft : holdRight;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdRight <= '0;
      shiftReg  <= '0;
      sdoutReg  <= 1'b0;
    end else begin
      if (strobes.loadLeft) begin
        holdRight <= wordRight;
      end
      if (strobes.bitTick) begin
        if (strobes.loadLeft || strobes.loadRight) begin
          if (strobes.i2sMode) begin
            sdoutReg <= shiftReg[TOP];
            shiftReg <= loadWord;
          end else begin
            sdoutReg <= loadWord[TOP];
            shiftReg <= loadWord << 1;
          end
        end else begin
          sdoutReg <= shiftReg[TOP];
          shiftReg <= shiftReg << 1;
        end
      end
    end
  end

  assign sdout = sdoutReg;

  AST_QUIET_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.bitTick |=> $stable(sdoutReg)); // R3

  AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadLeft || strobes.loadRight) |-> strobes.bitTick); // R3

  AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadLeft && !strobes.useShort |=> holdRight == $past(rightSample)); // R9

  AST_SHORT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadLeft && strobes.useShort |=> holdRight[DROP_W-1:0] == '0); // R6

  AST_NO_SIGN_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadLeft && strobes.useShort && !rightSample[TOP] |=> !holdRight[TOP]); // R7

endmodule

// File: rtl/adc_serial_tx.sv
module adc_serial_tx
  import adc_serial_tx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SHORT_W     = 16,
  parameter int SHORT_RATIO = 32,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LFSR_W      = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclkIn,
  input  logic                lrckIn,
  input  logic                fmtI2s,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  output logic                sdout,
  output logic                fmtExport
);

  txStrobes_t strobes;
  logic       ditherBit;

  adc_serial_tx_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W),
    .SHORT_RATIO(SHORT_RATIO)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclkIn (sclkIn),
    .lrckIn (lrckIn),
    .fmtI2s (fmtI2s),
    .strobes(strobes)
  );

  adc_serial_tx_dither #(
    .LFSR_W(LFSR_W)
  ) u_dither (
    .clk      (clk),
    .rstN     (rstN),
    .step     (strobes.loadLeft),
    .ditherBit(ditherBit)
  );

  adc_serial_tx_dp #(
    .SAMPLE_W(SAMPLE_W),
    .SHORT_W (SHORT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .ditherBit  (ditherBit),
    .leftSample (leftSample),
    .rightSample(rightSample),
    .sdout      (sdout)
  );

  assign fmtExport = fmtI2s;

endmodule

// File: tb/adc_serial_tx_bench.sv
module adc_serial_tx_bench;

  localparam int HALF = 6;  // system clocks per bit-clock half period

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkIn = 1'b1;
  logic        lrckIn = 1'b0;
  logic        fmtI2s = 1'b0;
  logic [23:0] leftSample = '0;
  logic [23:0] rightSample = '0;
  logic        sdout, fmtExport;

  always #2 clk = ~clk;

  adc_serial_tx u_adc_serial_tx (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .lrckIn(lrckIn), .fmtI2s(fmtI2s),
    .leftSample(leftSample), .rightSample(rightSample),
    .sdout(sdout), .fmtExport(fmtExport)
  );

  int checks = 0;
  int fails = 0;
  int satSeen = 0;
  bit done = 0;

  // reference model state
  logic [15:0] mLfsr;
  logic        expShort, haveMeas, lastMeas;
  int          evCount, prevFrameB, prevB;
  logic [23:0] prevWord;

  function automatic logic [23:0] expWord(logic [23:0] s, logic shortMode, logic d);
    int v;
    if (!shortMode) return s;
    v = $signed(s);
    v = v + (d ? 128 : 0);
    v = v >>> 8;
    if (v > 32767) v = 32767;
    return {16'(v), 8'h00};
  endfunction

  function automatic logic [15:0] lfsrNext(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [63:0] expSlots(logic i2s, int b, logic [23:0] w,
                                          logic [23:0] pw, int pb);
    logic [63:0] v = '0;
    for (int j = 0; j < b; j++) begin
      if (!i2s) v[j] = (j < 24) ? w[23-j] : 1'b0;
      else if (j == 0) v[j] = (pb <= 24) ? pw[24-pb] : 1'b0;
      else v[j] = (j <= 24) ? w[24-j] : 1'b0;
    end
    return v;
  endfunction

  task automatic check(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic driveHalf(int b, logic level, output logic [63:0] bits);
    bits = '0;
    for (int j = 0; j < b; j++) begin
      sclkIn = 1'b0;
      if (j == 0) lrckIn = level;
      repeat (HALF) @(negedge clk);
      bits[j] = sdout;
      sclkIn = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  // Reset, then an initial right half-frame of b slots. Covers R10, R11.
  task automatic startPhase(logic i2s, int b);
    logic [63:0] junk;
    @(negedge clk);
    rstN = 1'b0;
    fmtI2s = i2s;
    sclkIn = 1'b1;
    lrckIn = i2s;  // level of the right channel
    repeat (4) @(negedge clk);
    check("R11", "sdout in reset", {63'd0, sdout}, 64'd0);
    check("R10", "format export", {63'd0, fmtExport}, {63'd0, i2s});
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "sdout after reset", {63'd0, sdout}, 64'd0);
    mLfsr = 16'hACE1; expShort = 0; haveMeas = 0; lastMeas = 0;
    evCount = 0; prevFrameB = b;
    driveHalf(b, i2s, junk);
    prevWord = '0; prevB = b;
  endtask

  task automatic runFrame(string tag, int b, logic [23:0] l, logic [23:0] r);
    logic [63:0] got;
    logic [23:0] eL, eR;
    logic d, meas;
    evCount++;
    d = mLfsr[15];
    eL = expWord(l, expShort, d);
    eR = expWord(r, expShort, d);
    if (expShort && d && l[23:7] == {1'b0, 16'hFFFF}) satSeen++;
    mLfsr = lfsrNext(mLfsr);
    if (evCount >= 2) begin
      meas = (prevFrameB == 16);
      if (haveMeas && meas == lastMeas) expShort = meas;
      lastMeas = meas;
      haveMeas = 1;
    end
    prevFrameB = b;
    leftSample = l;
    rightSample = r;
    driveHalf(b, ~fmtI2s, got);
    check(tag, $sformatf("left frame %0d", evCount), got,
          expSlots(fmtI2s, b, eL, prevWord, prevB));
    prevWord = eL; prevB = b;
    driveHalf(b, fmtI2s, got);
    check(tag, $sformatf("right frame %0d", evCount), got,
          expSlots(fmtI2s, b, eR, prevWord, prevB));
    prevWord = eR; prevB = b;
  endtask

  initial begin
    logic [23:0] dirR [6];
    void'($urandom(32'd1234));
    dirR[0] = 24'h7FFF80; dirR[1] = 24'h800000; dirR[2] = 24'h000000;
    dirR[3] = 24'hFFFFFF; dirR[4] = 24'h123480; dirR[5] = 24'h80007F;

    // R1, R9: left-justified at 64 bit clocks per frame
    startPhase(1'b0, 32);
    for (int k = 0; k < 6; k++) runFrame("R1", 32, 24'($urandom), 24'($urandom));

    // R2, R9: I2S at 64
    startPhase(1'b1, 32);
    for (int k = 0; k < 6; k++) runFrame("R2", 32, 24'($urandom), 24'($urandom));

    // R3: I2S at 48, last bit spills into the next half-frame
    startPhase(1'b1, 24);
    for (int k = 0; k < 5; k++) runFrame("R3", 24, 24'($urandom), 24'($urandom));

    // R4, R6, R7, R8: left-justified at 32, full-scale left input
    startPhase(1'b0, 16);
    for (int k = 0; k < 12; k++)
      runFrame("R6", 16, 24'h7FFFFF, (k < 6) ? dirR[k] : 24'($urandom));
    checks++;
    if (satSeen == 0) begin
      fails++;
      $display("FAIL R7 saturation never exercised: got %0d expected >0", satSeen);
    end

    // R5, R4: I2S at 32, one odd frame, then a lasting change to 64
    startPhase(1'b1, 16);
    for (int k = 0; k < 8; k++) runFrame("R4", 16, 24'($urandom), 24'($urandom));
    runFrame("R5", 32, 24'($urandom), 24'($urandom));
    for (int k = 0; k < 4; k++) runFrame("R5", 16, 24'($urandom), 24'h7FFFC0);
    for (int k = 0; k < 6; k++) runFrame("R4", 32, 24'($urandom), 24'($urandom));

    check("R10", "format export final", {63'd0, fmtExport}, {63'd0, fmtI2s});
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule